// File: doc/BRIEF.md
# MSI Receive and Interrupt Aggregator

This block watches a stream of inbound memory writes and picks out the ones that are message-signalled interrupts for this host. A write is accepted when its address equals a programmed target, the receiver is enabled, and its 16-bit payload carries a fixed pattern under a programmable compare mask. The low payload bits of an accepted write name one of up to 32 vectors. The block latches that vector in a pending-status register.

Software controls the block through a small word-indexed register port. It programs the target address and the enable bit, and it sets the payload pattern. It reads the pending vectors and clears them by writing ones, and it masks or unmasks vectors through separate set and clear registers. Every pending vector that is not masked feeds one registered interrupt line. Writes that are rejected are counted in a saturating counter that software can read.

Top module: `msi_rx_agg`

## Requirements
- R1: A write can hit only when the enable bit (index 0, bit 0) is 1 and msg_addr[ADDR_W-1:2] equals the concatenation of the high-address register (index 1) and bits 31:2 of index 0. msg_addr[1:0] is not compared.
- R2: The upper half of the pattern register (index 2, bits 31:16) is a compare mask. The payload matches when every masked payload bit equals the same bit of index 2 bits 15:0. The vector number is msg_data[4:0].
- R3: A hit sets the pending bit of its vector. The change is visible in the status register (index 3) right after the clock edge that captures the write.
- R4: A write that misses on address or payload, or that arrives while the block is disabled, changes no pending bit and adds one to the drop count (index 7). The count stops at 255.
- R5: Writing to index 4 clears each pending bit whose write-data bit is 1 and leaves the other pending bits alone. Index 4 always reads 0.
- R6: If a hit sets a vector in the same cycle that an index 4 write clears it, the bit ends up set.
- R7: Writing ones to index 5 masks those vectors, and writing ones to index 6 unmasks them. Both indices read back the current mask.
- R8: irq_o is 1 exactly one cycle after a cycle in which some pending bit had its mask bit at 0.
- R9: After reset, the status register, the enable bit, the drop count and irq_o are all 0, and every vector is masked.
- R10: Index 0 reads back the stored address bits 31:2 together with the enable bit in bit 0; bit 1 always reads 0. Index 1 and index 2 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | An inbound memory write is present this cycle |
| msg_addr | input | ADDR_W | Byte address of the inbound write |
| msg_data | input | 16 | Payload of the inbound write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: 32 vectors, a 64-bit address, an 8-bit drop counter and a registered interrupt. With all 32 vectors present, both the lowest and the highest vector numbers can be reached. With 8 counter bits, the counter reaches saturation after a few hundred rejected writes. Because the address is 64 bits wide, a single flipped bit anywhere in the compared range, including the upper word, can be placed to cause a miss.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
   typedef enum logic [2:0] {
      RG_TGT_LO = 3'd0,
      RG_TGT_HI = 3'd1,
      RG_PATTERN = 3'd2,
      RG_PENDING = 3'd3,
      RG_ACK = 3'd4,
      RG_MASK_ON = 3'd5,
      RG_MASK_OFF = 3'd6,
      RG_DROPS = 3'd7
   } msi_reg_e;

   localparam int unsigned PAYLOAD_W = 16;
   localparam int unsigned REG_W = 32;
endpackage

// File: rtl/msi_match.sv
module msi_match
   import msi_rx_pkg::*;
#(
   parameter int unsigned NUM_VEC = 32,
   parameter int unsigned ADDR_W = 64,
   localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic                  msg_valid,
   input  logic [ADDR_W-1:0]     msg_addr,
   input  logic [PAYLOAD_W-1:0]  msg_data,
   input  logic                  enable,
   input  logic [ADDR_W-1:2]     target,
   input  logic [REG_W-1:0]      pattern,
   output logic                  hit,
   output logic                  miss,
   output logic [VEC_W-1:0]      vec
);
   logic addr_ok;
   logic data_ok;
   logic range_ok;

   assign addr_ok = (msg_addr[ADDR_W-1:2] == target);
   assign data_ok = (((msg_data ^ pattern[PAYLOAD_W-1:0]) &
                      pattern[REG_W-1:PAYLOAD_W]) == '0);
   assign vec = msg_data[VEC_W-1:0];

   generate
      if (NUM_VEC == (1 << VEC_W)) begin : g_full_range
         assign range_ok = 1'b1;
      end else begin : g_part_range
         assign range_ok = (32'(vec) < NUM_VEC);
      end
   endgenerate

   assign hit = msg_valid && enable && addr_ok && data_ok && range_ok;
   assign miss = msg_valid && !hit;
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
   parameter int unsigned NUM_VEC = 32,
   localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit,
   input  logic [VEC_W-1:0]   vec,
   input  logic               ack_we,
   input  logic               mask_on_we,
   input  logic               mask_off_we,
   input  logic [NUM_VEC-1:0] wbits,
   output logic [NUM_VEC-1:0] pending,
   output logic [NUM_VEC-1:0] mask
);
   generate
      for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
         logic pend_q;
         logic mask_q;
         logic set_here;
         assign set_here = hit && (32'(vec) == i);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else if (set_here) begin
               pend_q <= 1'b1;
            end else if (ack_we && wbits[i]) begin
               pend_q <= 1'b0;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask_q <= 1'b1;
            end else if (mask_on_we && wbits[i]) begin
               mask_q <= 1'b1;
            end else if (mask_off_we && wbits[i]) begin
               mask_q <= 1'b0;
            end
         end

         assign pending[i] = pend_q;
         assign mask[i] = mask_q;
      end
   endgenerate
endmodule

// File: rtl/msi_drop_ctr.sv
module msi_drop_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (bump && (count != '1)) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/msi_rx_agg.sv
module msi_rx_agg
   import msi_rx_pkg::*;
#(
   parameter int unsigned NUM_VEC = 32,
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DROP_W = 8,
   parameter bit REG_IRQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [ADDR_W-1:0] msg_addr,
   input  logic [15:0]       msg_data,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_o
);
   localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

   generate
      if (NUM_VEC < 1 || NUM_VEC > 32) begin : g_bad_vec
         $error("NUM_VEC must lie in 1..32");
      end
      if (ADDR_W < 34 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must lie in 34..64");
      end
      if (DROP_W < 1 || DROP_W > 32) begin : g_bad_drop
         $error("DROP_W must lie in 1..32");
      end
   endgenerate

   msi_reg_e          sel;
   logic [31:2]       tgt_lo_q;
   logic              en_q;
   logic [31:0]       tgt_hi_q;
   logic [31:0]       pattern_q;
   logic [63:0]       tgt_full;
   logic              hit;
   logic              miss;
   logic [VEC_W-1:0]  hit_vec;
   logic [NUM_VEC-1:0] status;
   logic [NUM_VEC-1:0] mask;
   logic [DROP_W-1:0] drop_cnt;
   logic              irq_next;

   assign sel = msi_reg_e'(reg_addr);
   assign tgt_full = {tgt_hi_q, tgt_lo_q, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_lo_q <= '0;
         en_q <= 1'b0;
         tgt_hi_q <= '0;
         pattern_q <= '0;
      end else if (reg_wr) begin
         case (sel)
            RG_TGT_LO: begin
               tgt_lo_q <= reg_wdata[31:2];
               en_q <= reg_wdata[0];
            end
            RG_TGT_HI: tgt_hi_q <= reg_wdata;
            RG_PATTERN: pattern_q <= reg_wdata;
            default: ;
         endcase
      end
   end

   msi_match #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_match (
      .msg_valid(msg_valid),
      .msg_addr(msg_addr),
      .msg_data(msg_data),
      .enable(en_q),
      .target(tgt_full[ADDR_W-1:2]),
      .pattern(pattern_q),
      .hit(hit),
      .miss(miss),
      .vec(hit_vec)
   );

   msi_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
      .clk(clk),
      .rst_n(rst_n),
      .hit(hit),
      .vec(hit_vec),
      .ack_we(reg_wr && (sel == RG_ACK)),
      .mask_on_we(reg_wr && (sel == RG_MASK_ON)),
      .mask_off_we(reg_wr && (sel == RG_MASK_OFF)),
      .wbits(reg_wdata[NUM_VEC-1:0]),
      .pending(status),
      .mask(mask)
   );

   msi_drop_ctr #(.CNT_W(DROP_W)) u_drops (
      .clk(clk),
      .rst_n(rst_n),
      .bump(miss),
      .count(drop_cnt)
   );

   assign irq_next = |(status & ~mask);

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= irq_next;
            end
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_next;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (sel)
         RG_TGT_LO: reg_rdata = {tgt_lo_q, 1'b0, en_q};
         RG_TGT_HI: reg_rdata = tgt_hi_q;
         RG_PATTERN: reg_rdata = pattern_q;
         RG_PENDING: reg_rdata[NUM_VEC-1:0] = status;
         RG_MASK_ON, RG_MASK_OFF: reg_rdata[NUM_VEC-1:0] = mask;
         RG_DROPS: reg_rdata[DROP_W-1:0] = drop_cnt;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/msi_rx_agg_chk.sv
module msi_rx_agg_chk #(
   parameter int unsigned NUM_VEC = 32,
   parameter int unsigned DROP_W = 8,
   parameter bit REG_IRQ = 1'b1,
   localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msg_valid,
   input logic               hit,
   input logic [VEC_W-1:0]   vec,
   input logic               en,
   input logic               reg_wr,
   input logic [2:0]         reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [NUM_VEC-1:0] status,
   input logic [NUM_VEC-1:0] mask,
   input logic [DROP_W-1:0]  drops,
   input logic               irq
);
   AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !en) |-> !hit); // R1

   AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> status[$past(vec)]); // R3

   AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status)) != '0) |-> $past(hit)); // R4

   AST_DROP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (drops == '1) |=> (drops == '1)); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd4 && !hit) |=>
      ((status & $past(reg_wdata[NUM_VEC-1:0])) == '0)); // R5

   AST_MASK_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd5) |=>
      ((mask & $past(reg_wdata[NUM_VEC-1:0])) == $past(reg_wdata[NUM_VEC-1:0]))); // R7

   generate
      if (REG_IRQ) begin : g_irq_chk
         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past((status & ~mask) != '0)); // R8
      end
   endgenerate
endmodule

bind msi_rx_agg msi_rx_agg_chk #(
   .NUM_VEC(NUM_VEC),
   .DROP_W(DROP_W),
   .REG_IRQ(REG_IRQ)
) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .msg_valid(msg_valid),
   .hit(hit),
   .vec(hit_vec),
   .en(en_q),
   .reg_wr(reg_wr),
   .reg_addr(reg_addr),
   .reg_wdata(reg_wdata),
   .status(status),
   .mask(mask),
   .drops(drop_cnt),
   .irq(irq_o)
);

// File: tb/test_msi_rx_agg.sv
`timescale 1ns/100ps
module test_msi_rx_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_valid = 1'b0;
   logic [63:0] msg_addr = '0;
   logic [15:0] msg_data = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [63:0] m_tgt;
   logic        m_en;
   logic [31:0] m_pat;
   logic [31:0] m_st;
   logic [31:0] m_mk;
   int          m_drops;

   localparam logic [63:0] TGT = 64'h0000_000F_FFFF_FFFC;

   always #2.5 clk = ~clk;

   msi_rx_agg i_msi_rx_agg (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
      .msg_data(msg_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_hit(input logic mv, input logic [63:0] a, input logic [15:0] d);
      return mv && m_en && (a[63:2] == m_tgt[63:2]) &&
             (((d ^ m_pat[15:0]) & m_pat[31:16]) == 16'h0);
   endfunction

   task automatic rd(input logic [2:0] idx, output logic [31:0] v);
      reg_addr = idx;
      #0.2;
      v = reg_rdata;
   endtask

   // One clock with optional message and register write, model update and checks.
   task automatic step(input logic mv, input logic [63:0] a, input logic [15:0] d,
                       input logic rw, input logic [2:0] ra, input logic [31:0] wd);
      logic hit;
      logic irq_exp;
      logic [31:0] v;
      hit = exp_hit(mv, a, d);
      irq_exp = |(m_st & ~m_mk);
      msg_valid = mv; msg_addr = a; msg_data = d;
      reg_wr = rw; reg_addr = ra; reg_wdata = wd;
      if (rw) begin
         case (ra)
            3'd0: begin m_tgt[31:0] = {wd[31:2], 2'b00}; m_en = wd[0]; end
            3'd1: m_tgt[63:32] = wd;
            3'd2: m_pat = wd;
            3'd4: m_st = m_st & ~wd;
            3'd5: m_mk = m_mk | wd;
            3'd6: m_mk = m_mk & ~wd;
            default: ;
         endcase
      end
      if (hit) m_st[d[4:0]] = 1'b1;
      if (mv && !hit && m_drops != 255) m_drops++;
      @(posedge clk);
      #1;
      msg_valid = 1'b0; reg_wr = 1'b0;
      check("R8 irq", {31'b0, irq_o}, {31'b0, irq_exp});
      rd(3'd3, v); check("R3 status", v, m_st);
      rd(3'd5, v); check("R7 mask", v, m_mk);
      rd(3'd7, v); check("R4 drops", v, 32'(m_drops));
      @(negedge clk);
   endtask

   task automatic idle();
      step(1'b0, '0, '0, 1'b0, 3'd0, '0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      m_tgt = '0; m_en = 1'b0; m_pat = '0; m_st = '0; m_mk = '1; m_drops = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check("R9 irq at reset", {31'b0, irq_o}, 32'h0);
      rd(3'd3, v); check("R9 status at reset", v, 32'h0);
      rd(3'd5, v); check("R9 mask at reset", v, 32'hFFFF_FFFF);
      rd(3'd7, v); check("R9 drops at reset", v, 32'h0);
      rd(3'd0, v); check("R9 enable at reset", v, 32'h0);

      // R1 disabled: a matching write is dropped
      step(1'b1, TGT, 16'h6540, 1'b0, 3'd0, '0);

      step(1'b0, '0, '0, 1'b1, 3'd1, TGT[63:32]);
      step(1'b0, '0, '0, 1'b1, 3'd0, TGT[31:0] | 32'h3);
      rd(3'd0, v); check("R10 target low readback", v, 32'hFFFF_FFFD);
      rd(3'd1, v); check("R10 target high readback", v, 32'h0000_000F);
      step(1'b0, '0, '0, 1'b1, 3'd2, 32'hFFE0_6540);
      rd(3'd2, v); check("R10 pattern readback", v, 32'hFFE0_6540);
      step(1'b0, '0, '0, 1'b1, 3'd6, 32'hFFFF_FFFF);

      // R2 boundary vectors 0 and 31, low address bits ignored (R1)
      step(1'b1, TGT | 64'h3, 16'h6540, 1'b0, 3'd0, '0);
      step(1'b1, TGT, 16'h655F, 1'b0, 3'd0, '0);
      idle();
      // R1 address miss in upper word and just above bit 2
      step(1'b1, TGT ^ 64'h4, 16'h6541, 1'b0, 3'd0, '0);
      step(1'b1, TGT ^ 64'h0000_0008_0000_0000, 16'h6541, 1'b0, 3'd0, '0);
      // R2 payload miss in a compared bit
      step(1'b1, TGT, 16'h6D42, 1'b0, 3'd0, '0);
      // R5 ack reads 0 and clears chosen bits
      rd(3'd4, v); check("R5 ack reads zero", v, 32'h0);
      step(1'b0, '0, '0, 1'b1, 3'd4, 32'h0000_0001);
      // R6 set and clear of vector 7 in one cycle
      step(1'b1, TGT, 16'h6547, 1'b1, 3'd4, 32'h8000_0080);
      idle();
      // R7 mask everything, irq drops
      step(1'b0, '0, '0, 1'b1, 3'd5, 32'hFFFF_FFFF);
      idle();
      step(1'b0, '0, '0, 1'b1, 3'd6, 32'h0000_0080);
      idle();

      for (int k = 0; k < 3000; k++) begin
         logic mv;
         logic [63:0] a;
         logic [15:0] d;
         logic rw;
         logic [2:0] ra;
         logic [31:0] wd;
         mv = ($urandom % 4) != 0;
         a = TGT | 64'($urandom % 4);
         if (($urandom % 10) < 3) a = a ^ (64'h1 << (2 + ($urandom % 62)));
         d = 16'h6540 | 16'($urandom % 32);
         if (($urandom % 10) < 3) d = 16'($urandom);
         rw = ($urandom % 3) == 0;
         ra = 3'(4 + ($urandom % 3));
         wd = $urandom & $urandom;
         if (($urandom % 40) == 0) begin
            ra = 3'd0;
            wd = TGT[31:0] | 32'(!m_en);
         end
         step(mv, a, d, rw, ra, wd);
      end

      // R4 saturation of the drop counter
      for (int k = 0; k < 300; k++) step(1'b1, ~TGT, 16'h0, 1'b0, 3'd0, '0);
      rd(3'd7, v); check("R4 drops saturated", v, 32'd255);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule